// File: doc/BRIEF.md
# Host Bridge Address Decoder

This block sits at the CPU side of a bus host bridge and sorts each physical address into one of four fixed windows: configuration space, I/O space, bus memory space and a boot ROM at the very top of the 32-bit map. For each request it reports which window was hit and the address to present on the bus side. For configuration hits it also reports a device number and a register offset. An address that falls in no window raises a decode error, and a read that misses returns all-ones.

Configuration accesses use one-hot device selection. The device number is the position of the lowest set bit within a band of eleven address bits above the register offset. The first 8 MiB of I/O space passes through a compaction stage with two modes, chosen by a level input. In contiguous mode the stage keeps a dense 64 KiB port range. In sparse mode it drops the middle address bits, so that each 4 KiB page carries 32 ports. Decode is combinational, and all results appear on registered outputs one cycle after a valid request.

Top module: `hbr_addr_decode`

## Requirements
- R1: Addresses 0x8080_0000 to 0x80BF_FFFF decode as configuration space, reported as region code 1.
- R2: For a configuration hit, the device number is the index of the lowest set bit among address bits 11..21, counted from bit 11 as 0. It is 11 when none of those bits is set.
- R3: For a configuration hit, the register offset is address bits [10:0] and the bus address is {device[3:0], offset[10:0]}, zero-extended to 32 bits.
- R4: Addresses 0x8000_0000 to 0xBF7F_FFFF that are not configuration space decode as I/O, reported as region code 2. Above the first 8 MiB, the bus address is the address minus 0x8000_0000. Within the first 8 MiB, the compaction of R5/R6 applies.
- R5: With io_sparse low, the compacted I/O bus address is the window offset ANDed with 0xFFFF.
- R6: With io_sparse high, the compacted I/O bus address is offset[4:0] ORed with (offset AND 0x07FF_F000) shifted right by 7.
- R7: io_sparse is sampled on the clock edge that captures each request, so a change applies from the very next request.
- R8: Addresses 0xC000_0000 to 0xFEFF_FFFF decode as bus memory, reported as region code 3, with bus address equal to the address minus 0xC000_0000.
- R9: Addresses 0xFFF0_0000 to 0xFFFF_FFFF decode as boot ROM, reported as region code 4, with bus address equal to address bits [19:0].
- R10: Any other address gives region code 0 and out_err high. out_err_rdata is 0xFFFF_FFFF for a read and 0 for a write. For every hit, out_err is low and out_err_rdata is 0.
- R11: out_valid is high exactly one cycle after each cycle with req_valid high. The registered results, size and write flag hold their value while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | CPU physical address |
| req_size | input | 3 | Access size in bytes (1, 2 or 4), passed through |
| req_write | input | 1 | 1 for write, 0 for read |
| io_sparse | input | 1 | I/O compaction mode: 0 contiguous, 1 sparse |
| out_valid | output | 1 | Registered result present |
| out_region | output | 3 | 0 none, 1 config, 2 I/O, 3 memory, 4 ROM |
| out_bus_addr | output | 32 | Translated bus-side address |
| out_cfg_dev | output | 4 | Configuration device number |
| out_cfg_off | output | 11 | Configuration register offset |
| out_err | output | 1 | Decode miss |
| out_err_rdata | output | 32 | Read fill data for a miss |
| out_size | output | 3 | Registered access size |
| out_write | output | 1 | Registered write flag |

## Verification
Random addresses are drawn inside each window, with a random mode, size and direction, and checked against a bench model of the map. This shows whether every window translates correctly and whether both compaction modes differ exactly where they should. Directed addresses sit on every window edge and in the gaps between windows (0xBF80_0000, 0xFF00_0000, below 0x8000_0000), which separates a wrong bound from a wrong translation. Configuration addresses with no band bit, a single band bit, or several band bits show whether the lowest-bit priority and the none-set value of 11 are right. The same I/O address is sent back to back with the mode flipped, which exposes any delay in taking up the mode.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  typedef enum logic [2:0] {
    REG_NONE = 3'd0,
    REG_CFG  = 3'd1,
    REG_IO   = 3'd2,
    REG_MEM  = 3'd3,
    REG_ROM  = 3'd4
  } hbr_region_e;
endpackage

// File: rtl/hbr_window_match.sv
module hbr_window_match #(
  parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
  parameter logic [31:0] CFG_SIZE  = 32'h0040_0000,
  parameter logic [31:0] IO_BASE   = 32'h8000_0000,
  parameter logic [31:0] IO_SIZE   = 32'h3F80_0000,
  parameter logic [31:0] PACK_SIZE = 32'h0080_0000,
  parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
  parameter logic [31:0] MEM_SIZE  = 32'h3F00_0000,
  parameter logic [31:0] ROM_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] ROM_SIZE  = 32'h0010_0000
) (
  input  logic [31:0]         addr,
  output hbr_pkg::hbr_region_e region,
  output logic                in_pack
);
  import hbr_pkg::*;

  function automatic logic in_win(input logic [31:0] a, input logic [31:0] b,
                                  input logic [31:0] s);
    logic [32:0] lo;
    logic [32:0] hi;
    lo = {1'b0, b};
    hi = {1'b0, b} + {1'b0, s};
    return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
  endfunction

  logic hit_cfg, hit_io, hit_pack, hit_mem, hit_rom;

  always_comb begin
    hit_cfg  = in_win(addr, CFG_BASE, CFG_SIZE);
    hit_io   = in_win(addr, IO_BASE, IO_SIZE);
    hit_pack = in_win(addr, IO_BASE, PACK_SIZE);
    hit_mem  = in_win(addr, MEM_BASE, MEM_SIZE);
    hit_rom  = in_win(addr, ROM_BASE, ROM_SIZE);
    in_pack  = hit_pack;
    // priority: compacting I/O, then config, then plain I/O
    if (hit_pack)      region = REG_IO;
    else if (hit_cfg)  region = REG_CFG;
    else if (hit_io)   region = REG_IO;
    else if (hit_mem)  region = REG_MEM;
    else if (hit_rom)  region = REG_ROM;
    else               region = REG_NONE;
  end
endmodule

// File: rtl/hbr_cfg_decode.sv
module hbr_cfg_decode #(
  parameter int OFF_W = 11,
  parameter int SLOTS = 11,
  parameter int DEV_W = 4,
  localparam int IN_W = OFF_W + SLOTS
) (
  input  logic [IN_W-1:0]  addr,
  output logic [DEV_W-1:0] dev,
  output logic [OFF_W-1:0] off
);
  logic found;

  always_comb begin
    dev   = DEV_W'(SLOTS);
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!found && addr[OFF_W+i]) begin
        dev   = DEV_W'(i);
        found = 1'b1;
      end
    end
    off = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/hbr_io_compact.sv
module hbr_io_compact #(
  parameter int          PACK_W      = 23,
  parameter int          DENSE_W     = 16,
  parameter int          KEEP_LO     = 5,
  parameter int          PAGE_SHIFT  = 7,
  parameter logic [31:0] SPARSE_MASK = 32'h07FF_F000
) (
  input  logic [PACK_W-1:0] off,
  input  logic              sparse,
  output logic [31:0]       io_addr
);
  localparam logic [31:0] DENSE_MASK = (32'd1 << DENSE_W) - 32'd1;
  localparam logic [31:0] LO_MASK    = (32'd1 << KEEP_LO) - 32'd1;

  logic [31:0] off_w;

  always_comb begin
    off_w = 32'(off);
    if (sparse)
      io_addr = (off_w & LO_MASK) | ((off_w & SPARSE_MASK) >> PAGE_SHIFT);
    else
      io_addr = off_w & DENSE_MASK;
  end
endmodule

// File: rtl/hbr_addr_decode.sv
module hbr_addr_decode #(
  parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
  parameter logic [31:0] CFG_SIZE  = 32'h0040_0000,
  parameter logic [31:0] IO_BASE   = 32'h8000_0000,
  parameter logic [31:0] IO_SIZE   = 32'h3F80_0000,
  parameter int          PACK_W    = 23,
  parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
  parameter logic [31:0] MEM_SIZE  = 32'h3F00_0000,
  parameter int          ROM_W     = 20,
  parameter int          CFG_OFF_W = 11,
  parameter int          CFG_SLOTS = 11,
  parameter int          DEV_W     = 4,
  localparam logic [31:0] PACK_SIZE = 32'd1 << PACK_W,
  localparam logic [31:0] ROM_SIZE  = 32'd1 << ROM_W,
  localparam logic [31:0] ROM_BASE  = 32'd0 - ROM_SIZE,
  localparam int          CFG_IN_W  = CFG_OFF_W + CFG_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic [2:0]           req_size,
  input  logic                 req_write,
  input  logic                 io_sparse,
  output logic                 out_valid,
  output logic [2:0]           out_region,
  output logic [31:0]          out_bus_addr,
  output logic [DEV_W-1:0]     out_cfg_dev,
  output logic [CFG_OFF_W-1:0] out_cfg_off,
  output logic                 out_err,
  output logic [31:0]          out_err_rdata,
  output logic [2:0]           out_size,
  output logic                 out_write
);
  import hbr_pkg::*;

  hbr_region_e           region_c;
  logic                  in_pack_c;
  logic [DEV_W-1:0]      dev_c;
  logic [CFG_OFF_W-1:0]  off_c;
  logic [31:0]           io_pack_c;
  logic [31:0]           io_off_c;
  logic [31:0]           bus_c;
  logic                  err_c;
  logic [31:0]           fill_c;

  hbr_window_match #(
    .CFG_BASE (CFG_BASE),  .CFG_SIZE (CFG_SIZE),
    .IO_BASE  (IO_BASE),   .IO_SIZE  (IO_SIZE),
    .PACK_SIZE(PACK_SIZE),
    .MEM_BASE (MEM_BASE),  .MEM_SIZE (MEM_SIZE),
    .ROM_BASE (ROM_BASE),  .ROM_SIZE (ROM_SIZE)
  ) u_match (
    .addr   (req_addr),
    .region (region_c),
    .in_pack(in_pack_c)
  );

  hbr_cfg_decode #(
    .OFF_W(CFG_OFF_W), .SLOTS(CFG_SLOTS), .DEV_W(DEV_W)
  ) u_cfg (
    .addr(req_addr[CFG_IN_W-1:0]),
    .dev (dev_c),
    .off (off_c)
  );

  always_comb io_off_c = req_addr - IO_BASE;

  hbr_io_compact #(
    .PACK_W(PACK_W)
  ) u_io (
    .off    (io_off_c[PACK_W-1:0]),
    .sparse (io_sparse),
    .io_addr(io_pack_c)
  );

  // next-state translation
  always_comb begin
    unique case (region_c)
      REG_CFG: bus_c = 32'({dev_c, off_c});
      REG_IO:  bus_c = in_pack_c ? io_pack_c : io_off_c;
      REG_MEM: bus_c = req_addr - MEM_BASE;
      REG_ROM: bus_c = 32'(req_addr[ROM_W-1:0]);
      default: bus_c = 32'd0;
    endcase
    err_c  = (region_c == REG_NONE);
    fill_c = (err_c && !req_write) ? 32'hFFFF_FFFF : 32'd0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_region    <= 3'd0;
      out_bus_addr  <= 32'd0;
      out_cfg_dev   <= '0;
      out_cfg_off   <= '0;
      out_err       <= 1'b0;
      out_err_rdata <= 32'd0;
      out_size      <= 3'd0;
      out_write     <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_region    <= region_c;
        out_bus_addr  <= bus_c;
        out_cfg_dev   <= (region_c == REG_CFG) ? dev_c : '0;
        out_cfg_off   <= (region_c == REG_CFG) ? off_c : '0;
        out_err       <= err_c;
        out_err_rdata <= fill_c;
        out_size      <= req_size;
        out_write     <= req_write;
      end
    end
  end

  AST_CFG_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_region == 3'(REG_CFG)) |-> (out_cfg_dev <= DEV_W'(CFG_SLOTS))); // R2

  AST_IO_DENSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !io_sparse && req_addr >= IO_BASE && req_addr < IO_BASE + PACK_SIZE)
      |=> (out_region == 3'(REG_IO) && out_bus_addr[31:16] == 16'd0)); // R5

  AST_IO_SPARSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && io_sparse && req_addr >= IO_BASE && req_addr < IO_BASE + PACK_SIZE)
      |=> (out_bus_addr[4:0] == $past(req_addr[4:0]) && out_bus_addr[31:16] == 16'd0)); // R6

  AST_ROM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_region == 3'(REG_ROM)) |-> (out_bus_addr[31:ROM_W] == '0)); // R9

  AST_ERR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err && !out_write) |-> (out_err_rdata == 32'hFFFF_FFFF)); // R10

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R11

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !req_valid) |=> $stable(out_bus_addr)); // R11
endmodule

// File: tb/hbr_addr_decode_test.sv
module hbr_addr_decode_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic        req_write;
  logic        io_sparse;
  logic        out_valid;
  logic [2:0]  out_region;
  logic [31:0] out_bus_addr;
  logic [3:0]  out_cfg_dev;
  logic [10:0] out_cfg_off;
  logic        out_err;
  logic [31:0] out_err_rdata;
  logic [2:0]  out_size;
  logic        out_write;

  int checks;
  int failures;

  hbr_addr_decode uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .io_sparse(io_sparse),
    .out_valid(out_valid), .out_region(out_region), .out_bus_addr(out_bus_addr),
    .out_cfg_dev(out_cfg_dev), .out_cfg_off(out_cfg_off), .out_err(out_err),
    .out_err_rdata(out_err_rdata), .out_size(out_size), .out_write(out_write)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model of the address map
  function automatic logic [2:0] exp_region(input logic [31:0] a);
    if (a >= 32'h8000_0000 && a < 32'h8080_0000) return 3'd2;
    if (a >= 32'h8080_0000 && a < 32'h80C0_0000) return 3'd1;
    if (a >= 32'h80C0_0000 && a < 32'hBF80_0000) return 3'd2;
    if (a >= 32'hC000_0000 && a < 32'hFF00_0000) return 3'd3;
    if (a >= 32'hFFF0_0000) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [3:0] exp_dev(input logic [31:0] a);
    int k;
    k = 0;
    while (k < 11 && a[11+k] == 1'b0) k++;
    return 4'(k);
  endfunction

  function automatic logic [31:0] exp_bus(input logic [31:0] a, input logic sp);
    logic [31:0] o;
    case (exp_region(a))
      3'd1: return {17'd0, exp_dev(a), a[10:0]};
      3'd2: begin
        o = a - 32'h8000_0000;
        if (o < 32'h0080_0000) begin
          if (sp) return (o & 32'h1F) | ((o & 32'h07FF_F000) >> 7);
          else    return o & 32'hFFFF;
        end
        return o;
      end
      3'd3: return a - 32'hC000_0000;
      3'd4: return {12'd0, a[19:0]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic sp);
    case (exp_region(a))
      3'd1: return "R1/R2/R3";
      3'd2: return (a < 32'h8080_0000) ? (sp ? "R4/R6" : "R4/R5") : "R4";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [31:0] a, input logic sp, input logic wr, input logic [2:0] sz);
    logic [31:0] fill;
    logic [3:0]  d;
    logic [10:0] o;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; io_sparse = sp; req_write = wr; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    fill = (exp_region(a) == 3'd0 && !wr) ? 32'hFFFF_FFFF : 32'd0;
    d    = (exp_region(a) == 3'd1) ? exp_dev(a) : 4'd0;
    o    = (exp_region(a) == 3'd1) ? a[10:0] : 11'd0;
    check({tag_of(a, sp), " region/addr"},
          {29'd0, out_region, out_bus_addr}, {29'd0, exp_region(a), exp_bus(a, sp)});
    check({tag_of(a, sp), " cfg fields"}, {49'd0, out_cfg_dev, out_cfg_off}, {49'd0, d, o});
    check("R10 err/fill", {31'd0, out_err, out_err_rdata},
          {31'd0, exp_region(a) == 3'd0, fill});
    check("R11 valid/size/write", {59'd0, out_valid, out_size, out_write},
          {59'd0, 1'b1, sz, wr});
  endtask

  function automatic logic [2:0] rnd_size();
    case ($urandom % 3)
      0: return 3'd1;
      1: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    checks = 0; failures = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = 32'd0; req_size = 3'd1;
    req_write = 1'b0; io_sparse = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset state", {27'd0, out_valid, out_err, out_region, out_bus_addr},
          64'd0);
    rst_n = 1'b1;

    // directed corners: config device scan
    txn(32'h8080_0000, 1'b0, 1'b0, 3'd4);
    txn(32'h8080_0800, 1'b0, 1'b0, 3'd4);
    txn(32'h80A0_0000, 1'b0, 1'b1, 3'd4);
    txn(32'h8080_37FF, 1'b0, 1'b0, 3'd1);
    txn(32'h80BF_FFFF, 1'b1, 1'b0, 3'd2);
    // I/O compaction modes and edges
    txn(32'h8001_2345, 1'b0, 1'b0, 3'd1);
    txn(32'h8001_2345, 1'b1, 1'b0, 3'd1); // R7 mode flips on next request
    txn(32'h807F_FFFF, 1'b1, 1'b0, 3'd1);
    txn(32'h807F_FFFF, 1'b0, 1'b1, 3'd1);
    txn(32'h80C0_0000, 1'b1, 1'b0, 3'd4);
    txn(32'hBF7F_FFFF, 1'b0, 1'b0, 3'd1);
    // memory, ROM and holes
    txn(32'hBF80_0000, 1'b0, 1'b0, 3'd4);
    txn(32'hC000_0000, 1'b0, 1'b1, 3'd4);
    txn(32'hFEFF_FFFF, 1'b0, 1'b0, 3'd1);
    txn(32'hFF00_0000, 1'b0, 1'b1, 3'd4);
    txn(32'hFFF0_0000, 1'b0, 1'b0, 3'd4);
    txn(32'hFFFF_FFFF, 1'b1, 1'b0, 3'd1);
    txn(32'h7FFF_FFFF, 1'b0, 1'b0, 3'd4);
    txn(32'h0000_0000, 1'b0, 1'b0, 3'd2);

    // R7: back-to-back requests with the mode changing between them
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h8012_3456; io_sparse = 1'b0;
    req_write = 1'b0; req_size = 3'd2;
    @(negedge clk);
    check("R7 first mode", {32'd0, out_bus_addr}, {32'd0, exp_bus(32'h8012_3456, 1'b0)});
    io_sparse = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 next mode", {32'd0, out_bus_addr}, {32'd0, exp_bus(32'h8012_3456, 1'b1)});
    held = out_bus_addr;
    req_addr = 32'hC123_4567;
    @(negedge clk);
    check("R11 hold without request", {31'd0, out_valid, out_bus_addr}, {31'd0, 1'b0, held});

    // random traffic biased toward every window
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      case ($urandom % 6)
        0: a = 32'h8000_0000 + ($urandom & 32'h007F_FFFF);
        1: a = 32'h8080_0000 + ($urandom & 32'h003F_FFFF);
        2: a = 32'h80C0_0000 + ($urandom % 32'h3EC0_0000);
        3: a = 32'hC000_0000 + ($urandom % 32'h3F00_0000);
        4: a = 32'hFFF0_0000 + ($urandom & 32'h000F_FFFF);
        default: a = $urandom;
      endcase
      txn(a, 1'($urandom), 1'($urandom), rnd_size());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule